// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Dead-Time Gap

This block sits between a PWM generator and the two gate drivers of a half-bridge leg. It takes two synchronous requests, one for the upper switch and one for the lower switch, and produces two gate-enable outputs that are never high in the same cycle.

Arbitration is first-come. The request seen high first is granted and holds its output for as long as it stays high. The opposite request has no effect while the grant is held. When a granted output drops, both outputs stay low for a programmable number of clock cycles. After that gap, a request that was waiting on the other side takes precedence.

Two supply-good flags gate the outputs combinationally, so a lost rail turns the affected output off in the same cycle. A bad main rail turns off both outputs. A bad floating (bootstrap) rail turns off only the upper output. While either output is forced off, the arbiter treats the matching request as absent.

Top module: `hb_interlock`

## Requirements
- R1: `gate_hi` and `gate_lo` are never both 1 in any cycle.
- R2: From the idle state, a request alone appears non-inverted on its own output after the next rising clock edge: `req_hi`=1 gives `gate_hi`=1, and `req_lo`=1 gives `gate_lo`=1.
- R3: When both requests are sampled 0 at a clock edge, both outputs are 0 after that edge.
- R4: While a granted request stays 1, its output stays 1 and the opposite request has no effect on either output.
- R5: When a granted output drops, both outputs stay 0 for exactly `DT_CYCLES` cycles (`DT_CYCLES` ≥ 1). The opposite output then asserts if its request is still 1.
- R6: If both requests are first seen 1 on the same edge from idle, only `gate_hi` asserts.
- R7: If the waiting request drops during the gap, its output never asserts.
- R8: `rail_main_ok`=0 forces both outputs to 0 in the same cycle, and the arbiter treats both requests as 0.
- R9: `rail_float_ok`=0 forces `gate_hi` to 0 in the same cycle and treats `req_hi` as 0. The low side still works normally.
- R10: Both outputs are 0 while `rst_n` is 0 and stay 0 after release until a request is granted.
- R11: At the end of a gap, a waiting opposite request wins over a renewed request on the side that just ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_hi | input | 1 | Upper-switch PWM request, synchronous |
| req_lo | input | 1 | Lower-switch PWM request, synchronous |
| rail_main_ok | input | 1 | Main supply above its lockout level |
| rail_float_ok | input | 1 | Floating supply above its lockout level |
| gate_hi | output | 1 | Upper-switch gate enable |
| gate_lo | output | 1 | Lower-switch gate enable |

## Verification
The bound checker checks the following on every cycle:
- the outputs are mutually exclusive;
- each rail flag forces its outputs off;
- both outputs are off one edge after both requests are low;
- a held grant persists;
- an output never rises until the opposite output has been low for at least `DT_CYCLES` cycles, measured by counters in the checker.

Some behaviours depend on which request came first or on what a waiting request does during the gap. Only the directed scenarios show these:
- the tie going to the upper side;
- exact gap length before a pending request is served;
- cancellation of a request that drops mid-gap;
- precedence of the waiting side over a renewed request.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_LO   = 2'd2,
    ST_GAP  = 2'd3
  } hbi_state_e;

  typedef enum logic {
    SIDE_HI = 1'b0,
    SIDE_LO = 1'b1
  } hbi_side_e;
endpackage

// File: rtl/hbi_rst_sync.sv
module hbi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/hbi_req_qual.sv
module hbi_req_qual (
  input  logic req_hi,
  input  logic req_lo,
  input  logic rail_main_ok,
  input  logic rail_float_ok,
  output logic eff_hi,
  output logic eff_lo
);
  // A request only counts when the rail feeding its driver is good.
  always_comb begin
    eff_hi = req_hi & rail_main_ok & rail_float_ok;
    eff_lo = req_lo & rail_main_ok;
  end
endmodule

// File: rtl/hbi_gap_timer.sv
module hbi_gap_timer #(
  parameter int DT_CYCLES = 2,
  localparam int CW = (DT_CYCLES < 2) ? 1 : $clog2(DT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expire
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (start) begin
      cnt_en = 1'b1;
      cnt_d  = CW'(DT_CYCLES);
    end else if (run && (cnt_q > CW'(1))) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CW'(1);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = run && (cnt_q == CW'(1));
endmodule

// File: rtl/hbi_arbiter.sv
module hbi_arbiter
  import hbi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eff_hi,
  input  logic       eff_lo,
  input  logic       gap_expire,
  output hbi_state_e state,
  output logic       gap_start
);
  hbi_state_e st_q, st_d;
  hbi_side_e  last_q, last_d;
  logic       last_en;

  always_comb begin
    st_d      = st_q;
    last_d    = last_q;
    last_en   = 1'b0;
    gap_start = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (eff_hi)      st_d = ST_HI;
        else if (eff_lo) st_d = ST_LO;
      end
      ST_HI: begin
        if (!eff_hi) begin
          st_d      = ST_GAP;
          gap_start = 1'b1;
          last_d    = SIDE_HI;
          last_en   = 1'b1;
        end
      end
      ST_LO: begin
        if (!eff_lo) begin
          st_d      = ST_GAP;
          gap_start = 1'b1;
          last_d    = SIDE_LO;
          last_en   = 1'b1;
        end
      end
      ST_GAP: begin
        if (gap_expire) begin
          // Side that waited through the gap is served ahead of a renewal.
          if (last_q == SIDE_HI) begin
            if (eff_lo)      st_d = ST_LO;
            else if (eff_hi) st_d = ST_HI;
            else             st_d = ST_IDLE;
          end else begin
            if (eff_hi)      st_d = ST_HI;
            else if (eff_lo) st_d = ST_LO;
            else             st_d = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= SIDE_HI;
    else if (last_en) last_q <= last_d;
  end

  assign state = st_q;
endmodule

// File: rtl/hb_interlock.sv
module hb_interlock
  import hbi_pkg::*;
#(
  parameter int DT_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_hi,
  input  logic req_lo,
  input  logic rail_main_ok,
  input  logic rail_float_ok,
  output logic gate_hi,
  output logic gate_lo
);
  logic       rst_sync_n;
  logic       eff_hi, eff_lo;
  logic       gap_start, gap_expire;
  hbi_state_e state;

  hbi_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hbi_req_qual u_qual (
    .req_hi        (req_hi),
    .req_lo        (req_lo),
    .rail_main_ok  (rail_main_ok),
    .rail_float_ok (rail_float_ok),
    .eff_hi        (eff_hi),
    .eff_lo        (eff_lo)
  );

  hbi_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .eff_hi     (eff_hi),
    .eff_lo     (eff_lo),
    .gap_expire (gap_expire),
    .state      (state),
    .gap_start  (gap_start)
  );

  hbi_gap_timer #(.DT_CYCLES(DT_CYCLES)) u_gap (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (gap_start),
    .run    (state == ST_GAP),
    .expire (gap_expire)
  );

  // Rail flags act combinationally so a lost supply cuts the gate at once.
  assign gate_hi = (state == ST_HI) & rail_main_ok & rail_float_ok;
  assign gate_lo = (state == ST_LO) & rail_main_ok;
endmodule

// File: rtl/hbi_checker.sv
module hbi_checker #(
  parameter int DT_CYCLES = 2,
  localparam int CW = (DT_CYCLES < 2) ? 1 : $clog2(DT_CYCLES + 1)
) (
  input logic clk,
  input logic rst_n,
  input logic req_hi,
  input logic req_lo,
  input logic rail_main_ok,
  input logic rail_float_ok,
  input logic gate_hi,
  input logic gate_lo
);
  logic [CW-1:0] idle_hi_q, idle_lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_hi_q <= CW'(DT_CYCLES);
      idle_lo_q <= CW'(DT_CYCLES);
    end else begin
      if (gate_hi)                          idle_hi_q <= '0;
      else if (idle_hi_q < CW'(DT_CYCLES))  idle_hi_q <= idle_hi_q + CW'(1);
      if (gate_lo)                          idle_lo_q <= '0;
      else if (idle_lo_q < CW'(DT_CYCLES))  idle_lo_q <= idle_lo_q + CW'(1);
    end
  end

  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  a_r3_both_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_hi && !req_lo) |=> (!gate_hi && !gate_lo));

  a_r4_hold_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi && req_hi && rail_main_ok && rail_float_ok) |=>
      (gate_hi || !rail_main_ok || !rail_float_ok));

  a_r4_hold_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_lo && req_lo && rail_main_ok) |=> (gate_lo || !rail_main_ok));

  a_r5_gap_before_hi: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> (idle_lo_q >= CW'(DT_CYCLES)));

  a_r5_gap_before_lo: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> (idle_hi_q >= CW'(DT_CYCLES)));

  a_r8_main_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rail_main_ok |-> (!gate_hi && !gate_lo));

  a_r9_float_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rail_float_ok |-> !gate_hi);
endmodule

bind hb_interlock hbi_checker #(.DT_CYCLES(DT_CYCLES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_hi        (req_hi),
  .req_lo        (req_lo),
  .rail_main_ok  (rail_main_ok),
  .rail_float_ok (rail_float_ok),
  .gate_hi       (gate_hi),
  .gate_lo       (gate_lo)
);

// File: tb/hb_interlock_bench.sv
`timescale 1ns/1ps
module hb_interlock_bench;
  localparam int DT = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic req_hi, req_lo, rail_main_ok, rail_float_ok;
  logic gate_hi, gate_lo;
  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;

  always #4 clk = ~clk;

  hb_interlock #(.DT_CYCLES(DT)) u_hb_interlock (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_hi        (req_hi),
    .req_lo        (req_lo),
    .rail_main_ok  (rail_main_ok),
    .rail_float_ok (rail_float_ok),
    .gate_hi       (gate_hi),
    .gate_lo       (gate_lo)
  );

  task automatic chk(input logic exp_hi, input logic exp_lo, input string tag);
    total++;
    if (gate_hi !== exp_hi || gate_lo !== exp_lo) begin
      bad++;
      $display("FAIL %s: actual hi=%b lo=%b expected hi=%b lo=%b",
               tag, gate_hi, gate_lo, exp_hi, exp_lo);
    end
  endtask

  // One rising edge passes; inputs change and outputs are read at the falling edge.
  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    req_hi = 0; req_lo = 0; rail_main_ok = 1; rail_float_ok = 1;
    repeat (DT + 2) step();
  endtask

  task automatic t_reset();
    rst_n = 0; req_hi = 1; req_lo = 0; rail_main_ok = 1; rail_float_ok = 1;
    repeat (3) step();
    #1 chk(0, 0, "R10 during reset");
    req_hi = 0;
    rst_n = 1;
    repeat (4) step();
    #1 chk(0, 0, "R10 after release");
  endtask

  task automatic t_follow();
    req_hi = 1; step(); #1 chk(1, 0, "R2 high side follows");
    req_hi = 0; step(); #1 chk(0, 0, "R3 both low");
    settle();
    req_lo = 1; step(); #1 chk(0, 1, "R2 low side follows");
    req_lo = 0; step(); #1 chk(0, 0, "R3 both low after lo");
    settle();
  endtask

  task automatic t_block_and_gap();
    req_hi = 1; step();
    req_lo = 1; step(); #1 chk(1, 0, "R4 opposite blocked");
    step(); #1 chk(1, 0, "R4 still blocked");
    req_hi = 0;
    for (int i = 0; i < DT; i++) begin
      step(); #1 chk(0, 0, "R5 gap both low");
    end
    step(); #1 chk(0, 1, "R5 pending served after gap");
    settle();
  endtask

  task automatic t_tie();
    req_hi = 1; req_lo = 1; step(); #1 chk(1, 0, "R6 tie goes high side");
    req_hi = 0;
    repeat (DT + 1) step();
    #1 chk(0, 1, "R6 loser served after gap");
    settle();
  endtask

  task automatic t_cancel();
    int seen = 0;
    req_lo = 1; step();
    req_hi = 1; step();
    req_lo = 0; step();
    req_hi = 0;
    for (int i = 0; i < DT + 3; i++) begin
      step();
      if (gate_hi) seen++;
    end
    total++;
    if (seen != 0) begin
      bad++;
      $display("FAIL R7: actual hi cycles=%0d expected 0", seen);
    end
    settle();
  endtask

  task automatic t_precedence();
    req_hi = 1; step();
    req_lo = 1; step();
    req_hi = 0; step();
    req_hi = 1;
    repeat (DT) step();
    #1 chk(0, 1, "R11 waiting side wins");
    req_lo = 0;
    repeat (DT + 1) step();
    #1 chk(1, 0, "R11 renewed side after next gap");
    settle();
  endtask

  task automatic t_main_rail();
    req_hi = 1; step(); #1 chk(1, 0, "R8 precondition");
    rail_main_ok = 0; #1 chk(0, 0, "R8 same-cycle cut");
    req_lo = 1;
    repeat (DT + 2) step();
    #1 chk(0, 0, "R8 held off");
    settle();
  endtask

  task automatic t_float_rail();
    rail_float_ok = 0; req_hi = 1; step(); #1 chk(0, 0, "R9 high side off");
    req_lo = 1; step(); #1 chk(0, 1, "R9 low side usable");
    settle();
    req_hi = 1; step();
    rail_float_ok = 0; #1 chk(0, 0, "R9 same-cycle cut");
    settle();
  endtask

  initial begin
    t_reset();
    t_follow();
    t_block_and_gap();
    t_tie();
    t_cancel();
    t_precedence();
    t_main_rail();
    t_float_rail();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule